// File: doc/BRIEF.md
# Low-Power Wake-up Detector

This block watches a node's wake sources while the node sits in one of its low-power states. It recognises three kinds of request. A remote request is a dominant pulse on the bus receive line. The pulse counts only as a complete sequence: a falling edge, a dominant level held for a minimum number of cycles, and then the rising edge that ends it. A local request comes from a level switch on a dedicated wake pin. An ignition request is a low-to-high transition on the ignition input that stays high through a debounce interval.

The mode controller raises `lowpwr_i` while the node is in either the silent state or the sleep state. The detector is armed only while that flag is high and no wake has yet been recorded. The first qualifying event produces a one-cycle pulse and latches a 2-bit code that names the source. The code stays latched until the controller returns to normal operation. After a remote wake, the receive line passed to the host is forced low, so the host sees the request as an interrupt.

All three inputs are asynchronous. Each passes through a synchronizer of configurable depth before any edge is detected.

Top module: `lpm_wake_detector`

## Requirements
- R1: After reset, `wake_pulse_o` is 0, `wake_src_o` is 2'b00 and `rx_host_o` follows the synchronized bus level (1 when the bus is recessive).
- R2: While armed, a bus dominant level (0) that lasts at least FILT_CYCLES samples and then returns to recessive (1) gives one wake pulse and `wake_src_o` = 2'b01.
- R3: A dominant pulse shorter than FILT_CYCLES samples gives no wake and no code, and the detector accepts the next valid pulse.
- R4: A remote wake is signalled only on the rising edge that ends the dominant level. A bus held dominant without end gives no wake.
- R5: Outside a latched remote wake, `rx_host_o` mirrors the synchronized bus level. After a remote wake it is held at 0, whatever the bus does, until `lowpwr_i` falls.
- R6: While armed, the wake pin at its active level (low with the default polarity) gives one wake pulse and `wake_src_o` = 2'b10.
- R7: While armed, an ignition low-to-high edge that then stays high for DEB_CYCLES further samples gives one wake pulse and `wake_src_o` = 2'b11. A shorter high pulse does nothing, and a level already high when arming begins does nothing.
- R8: Detection is armed only while `lowpwr_i` is 1. Bus, pin and ignition events while it is 0 produce no pulse and leave the code at 2'b00.
- R9: Each low-power episode yields at most one single-cycle pulse. The code holds its value while `lowpwr_i` stays 1 and clears to 2'b00 one cycle after `lowpwr_i` is 0.
- R10: When sources qualify in the same cycle, the bus wins over the wake pin, and the wake pin wins over ignition.
- R11: Elaboration rejects FILT_CYCLES < 1, DEB_CYCLES < 1 and SYNC_STAGES < 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lowpwr_i | input | 1 | High while the node is in silent or sleep state |
| bus_rx_i | input | 1 | Bus receive level, 0 = dominant |
| wake_pin_i | input | 1 | Local wake switch input |
| ign_i | input | 1 | Ignition sense input |
| wake_pulse_o | output | 1 | One-cycle pulse on an accepted wake |
| wake_src_o | output | 2 | Latched source: 00 none, 01 bus, 10 pin, 11 ignition |
| rx_host_o | output | 1 | Receive level to the host, forced low after a remote wake |

## Verification
The bench builds the block with FILT_CYCLES = 8, DEB_CYCLES = 20 and two synchronizer stages. At the default ignition debounce of 16000 cycles, a debounce test would spend most of the run waiting. With the small values, the exact filter boundary (7 against 8 dominant samples), an aborted debounce and a completed debounce all fit into short directed scenarios. Driving two inputs on the same edge through equal synchronizer depth makes the bus and the wake pin qualify in the same cycle, which exercises the priority rule.

// File: rtl/lpm_wake_pkg.sv
package lpm_wake_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_BUS  = 2'b01,
      SRC_PIN  = 2'b10,
      SRC_IGN  = 2'b11
   } wake_src_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   // R11
   if (STAGES < 2) begin : g_bad_stages
      $error("lpm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[0] <= RST_VAL;
      else         stg[0] <= d_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg[i] <= RST_VAL;
         else         stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lpm_bus_filter.sv
module lpm_bus_filter #(
   parameter int FILT_CYCLES = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic armed_i,
   input  logic bus_i,
   output logic hit_o
);
   localparam int CW = $clog2(FILT_CYCLES + 1);
   localparam logic [CW-1:0] FILT_C = CW'(FILT_CYCLES);

   typedef enum logic {ST_IDLE, ST_DOM} st_e;
   st_e           st_q, st_n;
   logic [CW-1:0] cnt_q, cnt_n;
   logic          bus_d;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      hit_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (armed_i && !bus_i && bus_d) begin
               st_n  = ST_DOM;
               cnt_n = CW'(1);
            end
         end
         ST_DOM: begin
            if (!armed_i) begin
               st_n = ST_IDLE;
            end else if (!bus_i) begin
               if (cnt_q != FILT_C) cnt_n = cnt_q + CW'(1);
            end else begin
               st_n  = ST_IDLE;
               hit_o = (cnt_q >= FILT_C);
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         bus_d <= 1'b1;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         bus_d <= bus_i;
      end
   end

   // R4
   rise_ends_dom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> (bus_i && !$past(bus_i)));
endmodule

// File: rtl/lpm_ign_debounce.sv
module lpm_ign_debounce #(
   parameter int DEB_CYCLES = 16000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic armed_i,
   input  logic ign_i,
   output logic hit_o
);
   localparam int CW = $clog2(DEB_CYCLES + 1);
   localparam logic [CW-1:0] DEB_C = CW'(DEB_CYCLES);

   typedef enum logic {ST_IDLE, ST_CNT} st_e;
   st_e           st_q, st_n;
   logic [CW-1:0] cnt_q, cnt_n;
   logic          ign_d;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      hit_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (armed_i && ign_i && !ign_d) begin
               st_n  = ST_CNT;
               cnt_n = CW'(1);
            end
         end
         ST_CNT: begin
            if (!armed_i || !ign_i) begin
               st_n = ST_IDLE;
            end else if (cnt_q == DEB_C) begin
               st_n  = ST_IDLE;
               hit_o = 1'b1;
            end else begin
               cnt_n = cnt_q + CW'(1);
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         ign_d <= 1'b1;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         ign_d <= ign_i;
      end
   end

   // R7
   ign_stable_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> (ign_i && $past(ign_i)));
endmodule

// File: rtl/lpm_wake_detector.sv
module lpm_wake_detector #(
   parameter int FILT_CYCLES    = 8,
   parameter int DEB_CYCLES     = 16000,
   parameter int SYNC_STAGES    = 2,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       lowpwr_i,
   input  logic       bus_rx_i,
   input  logic       wake_pin_i,
   input  logic       ign_i,
   output logic       wake_pulse_o,
   output logic [1:0] wake_src_o,
   output logic       rx_host_o
);
   import lpm_wake_pkg::*;

   localparam logic PIN_IDLE = PIN_ACTIVE_LOW ? 1'b1 : 1'b0;

   // R11
   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("lpm_wake_detector: FILT_CYCLES must be at least 1");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("lpm_wake_detector: DEB_CYCLES must be at least 1");
   end

   logic [2:0] raw_in, sync_out;
   logic       bus_s, pin_s, ign_s, pin_act;

   assign raw_in = {ign_i, wake_pin_i, bus_rx_i};

   lpm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL({1'b1, PIN_IDLE, 1'b1})) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in),
      .q_o   (sync_out)
   );

   assign bus_s = sync_out[0];
   assign pin_s = sync_out[1];
   assign ign_s = sync_out[2];

   if (PIN_ACTIVE_LOW) begin : g_pin_low
      assign pin_act = ~pin_s;
   end else begin : g_pin_high
      assign pin_act = pin_s;
   end

   wake_src_e src_q, src_sel;
   logic      hold_q, pulse_q, armed;
   logic      bus_hit, ign_hit, any_hit;

   assign armed = lowpwr_i && (src_q == SRC_NONE);

   lpm_bus_filter #(.FILT_CYCLES(FILT_CYCLES)) u_bus (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .armed_i(armed),
      .bus_i  (bus_s),
      .hit_o  (bus_hit)
   );

   lpm_ign_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_ign (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .armed_i(armed),
      .ign_i  (ign_s),
      .hit_o  (ign_hit)
   );

   always_comb begin
      if (bus_hit)      src_sel = SRC_BUS;
      else if (pin_act) src_sel = SRC_PIN;
      else if (ign_hit) src_sel = SRC_IGN;
      else              src_sel = SRC_NONE;
   end

   assign any_hit = bus_hit || pin_act || ign_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q   <= SRC_NONE;
         hold_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else if (!lowpwr_i) begin
         src_q   <= SRC_NONE;
         hold_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else if (armed && any_hit) begin
         src_q   <= src_sel;
         hold_q  <= bus_hit;
         pulse_q <= 1'b1;
      end else begin
         pulse_q <= 1'b0;
      end
   end

   assign wake_pulse_o = pulse_q;
   assign wake_src_o   = src_q;
   assign rx_host_o    = hold_q ? 1'b0 : bus_s;

   // R9
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_pulse_o |=> !wake_pulse_o);
   // R9
   src_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_src_o != 2'b00 && lowpwr_i) |=> (wake_src_o == $past(wake_src_o)));
   // R8
   normal_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lowpwr_i |=> (wake_src_o == 2'b00 && !wake_pulse_o));
   // R8
   pulse_needs_lowpwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_pulse_o |-> $past(lowpwr_i));
   // R5
   bus_wake_rx_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_pulse_o && wake_src_o == 2'b01) |-> !rx_host_o);
   // R10
   bus_over_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && bus_hit && pin_act) |=> (wake_src_o == 2'b01));
endmodule

// File: tb/lpm_wake_detector_tb.sv
module lpm_wake_detector_tb_top;
   localparam int FILT = 8;
   localparam int DEB  = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lowpwr = 1'b0;
   logic       bus = 1'b1;
   logic       pin = 1'b1;
   logic       ign = 1'b0;
   logic       pulse;
   logic [1:0] src;
   logic       rxh;

   int checks = 0;
   int fails  = 0;
   int pulses = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   lpm_wake_detector #(.FILT_CYCLES(FILT), .DEB_CYCLES(DEB), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .lowpwr_i(lowpwr), .bus_rx_i(bus),
      .wake_pin_i(pin), .ign_i(ign), .wake_pulse_o(pulse),
      .wake_src_o(src), .rx_host_o(rxh)
   );

   always @(negedge clk) if (pulse) pulses++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enter_lp();
      @(negedge clk); lowpwr = 1'b1; cyc(3);
   endtask

   task automatic leave_lp();
      @(negedge clk); lowpwr = 1'b0; cyc(3);
   endtask

   task automatic dom_pulse(input int n);
      @(negedge clk); bus = 1'b0; cyc(n); bus = 1'b1;
   endtask

   task automatic t_reset();
      cyc(1);
      chk("R1 pulse", pulse, 0);
      chk("R1 src", src, 0);
      chk("R1 rx", rxh, 1);
   endtask

   task automatic t_bus_short_then_valid();
      int p0;
      enter_lp();
      p0 = pulses;
      dom_pulse(FILT - 1); cyc(8);
      chk("R3 no pulse", pulses - p0, 0);
      chk("R3 src", src, 0);
      dom_pulse(FILT); cyc(8);
      chk("R2 pulse", pulses - p0, 1);
      chk("R2 src", src, 1);
      chk("R5 rx held", rxh, 0);
      dom_pulse(FILT); cyc(8);
      chk("R9 one pulse", pulses - p0, 1);
      chk("R9 src held", src, 1);
      chk("R5 rx still held", rxh, 0);
      leave_lp();
      chk("R9 src cleared", src, 0);
      chk("R5 rx released", rxh, 1);
      @(negedge clk); bus = 1'b0; cyc(3);
      chk("R5 rx mirrors bus", rxh, 0);
      bus = 1'b1; cyc(3);
   endtask

   task automatic t_bus_hold();
      int p0;
      enter_lp();
      p0 = pulses;
      @(negedge clk); bus = 1'b0; cyc(60);
      chk("R4 no wake while dominant", pulses - p0, 0);
      bus = 1'b1; cyc(6);
      chk("R4 wake on release", pulses - p0, 1);
      chk("R4 src", src, 1);
      leave_lp();
   endtask

   task automatic t_pin();
      int p0;
      enter_lp();
      p0 = pulses;
      @(negedge clk); pin = 1'b0; cyc(6);
      chk("R6 pulse", pulses - p0, 1);
      chk("R6 src", src, 2);
      chk("R6 rx not held", rxh, 1);
      pin = 1'b1;
      leave_lp();
   endtask

   task automatic t_ign();
      int p0;
      enter_lp();
      p0 = pulses;
      @(negedge clk); ign = 1'b1; cyc(10); ign = 1'b0; cyc(10);
      chk("R7 short ignored", pulses - p0, 0);
      @(negedge clk); ign = 1'b1; cyc(DEB + 10);
      chk("R7 pulse", pulses - p0, 1);
      chk("R7 src", src, 3);
      leave_lp();
      cyc(2);
      p0 = pulses;
      enter_lp();
      cyc(DEB + 20);
      chk("R7 level not edge", pulses - p0, 0);
      ign = 1'b0;
      leave_lp();
   endtask

   task automatic t_normal_ignored();
      int p0;
      p0 = pulses;
      dom_pulse(FILT + 2);
      @(negedge clk); pin = 1'b0; cyc(5); pin = 1'b1;
      @(negedge clk); ign = 1'b1; cyc(DEB + 10); ign = 1'b0;
      cyc(5);
      chk("R8 no pulse", pulses - p0, 0);
      chk("R8 src", src, 0);
   endtask

   task automatic t_priority();
      int p0;
      enter_lp();
      p0 = pulses;
      @(negedge clk); bus = 1'b0; cyc(FILT + 2);
      bus = 1'b1; pin = 1'b0; cyc(6);
      chk("R10 pulse", pulses - p0, 1);
      chk("R10 bus wins", src, 1);
      pin = 1'b1;
      leave_lp();
   endtask

   initial begin
      cyc(3); rst_n = 1'b1;
      t_reset();
      t_bus_short_then_valid();
      t_bus_hold();
      t_pin();
      t_ign();
      t_normal_ignored();
      t_priority();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule